// File: doc/BRIEF.md
# Stored-Response Vector Sequencer

This block runs a functional test against a device by stepping through a small
vector memory one row per clock cycle. Each row carries a three-bit state code
for every device pin plus one sequencing micro-instruction. For each applied
row the block switches each pin driver on or off and sets the driven level. It
also compares the sampled device response with the stored expected level at the
clock edge that ends the cycle. Mismatches collect into sticky per-pin flags,
a global flag, and the address of the first row that failed.

The vector memory is loaded through a simple write port while the sequencer is
idle. A start pulse runs the program from address 0. The micro-instructions
can hold a row for several cycles, repeat a block of rows, jump elsewhere or
end the run. When the run ends the block reports done and releases all drivers.
Each pin has a sense input that tells the compare logic whether the pin is
floating. This lets a high-impedance expectation be checked without a fourth
logic value.

Top module: `tva_engine`

## Requirements
- R1: A row holds pin p's code in bits [3p+2:3p], the opcode in bits [3*NPINS+2:3*NPINS] and the operand in the OPW bits above. Code 000 drives 0 and code 001 drives 1, with the pin's driver enabled. Every other code leaves the driver disabled. While the block is idle, all drivers are disabled.
- R2: At the clock edge that ends a row's cycle, the compare rules are: code 010 (expect low) fails if the pin is floating or reads 1; code 011 (expect high) fails if the pin is floating or reads 0; code 100 (expect float) fails if the pin is not floating. Codes 000, 001, 101, 110 and 111 never fail.
- R3: A start pulse while idle begins a run at address 0 and clears all fail records. A start pulse during a run has no effect on the applied sequence.
- R4: Opcode 000 (advance) moves to the next address after one cycle. The spare opcodes 110 and 111 behave the same way.
- R5: Opcode 001 (repeat) holds the row for K cycles, where K is the operand and K=0 acts as 1. The row is compared in every one of those cycles, then the sequencer advances.
- R6: Opcode 010 (loop begin, operand M) applies its row once and marks the next address as the block start. Opcode 011 (loop end) returns to the block start until the block has run M times, with M=0 acting as 1, and then advances. Loops do not nest.
- R7: Opcode 100 (jump) applies its row once and then continues at the address given by the low AW bits of the operand.
- R8: Opcode 101 (halt) applies its row for one cycle. Then busy falls, done rises and all drivers turn off. Done stays high until the next start.
- R9: Each pin has a fail flag that is set by any mismatch on that pin during the run and stays set until the next start.
- R10: The global fail flag rises with the first mismatch of a run. The first-fail address then holds the address of the row that caused that mismatch and stays unchanged for the rest of the run.
- R11: After reset the block is idle: busy, done, all fail flags, the first-fail address and all driver enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write strobe for the vector memory |
| ld_addr | input | AW | Row address to write |
| ld_row | input | 3*NPINS+3+OPW | Row contents to write |
| start | input | 1 | Begin a run at address 0 when idle |
| pin_in | input | NPINS | Sampled logic level of each device pin |
| pin_z | input | NPINS | Per-pin flag, 1 when the pin is floating |
| drive_en | output | NPINS | Per-pin driver enable |
| drive_val | output | NPINS | Per-pin driven level |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run ended on a halt row |
| cur_addr | output | AW | Address of the row being applied |
| fail_pins | output | NPINS | Sticky per-pin fail flags |
| any_fail | output | 1 | Global fail flag |
| first_addr | output | AW | Address of the first failing row |

## Verification
The bench checks a repeat count of zero and a repeat that fails only in its last held cycle. A sequencer that treats zero as a long count, or compares only once per row, would then show an extra address or a missing fail flag. It also runs a loop with a count of zero, a jump whose operand has high bits set, and a start pulse in the middle of a run. Wrong counter reloads, a jump that ignores the truncation, or a restart that is not ignored would each show up as a different applied-address sequence. A run with mismatches of all three expect kinds on different rows checks that the flags stay set and that the first-fail address does not follow later failures.

// File: rtl/tva_pkg.sv
package tva_pkg;

  typedef enum logic [2:0] {
    OP_ADV  = 3'b000,
    OP_RPT  = 3'b001,
    OP_LBEG = 3'b010,
    OP_LEND = 3'b011,
    OP_JMP  = 3'b100,
    OP_HALT = 3'b101
  } op_e;

  typedef logic [2:0] pcode_t;

  localparam pcode_t PC_DRV0 = 3'b000;
  localparam pcode_t PC_DRV1 = 3'b001;
  localparam pcode_t PC_EXPL = 3'b010;
  localparam pcode_t PC_EXPH = 3'b011;
  localparam pcode_t PC_EXPZ = 3'b100;

  // True when the code turns the pin driver on.
  function automatic logic code_drives(input pcode_t c);
    return (c == PC_DRV0) || (c == PC_DRV1);
  endfunction

  // True when the sampled pin disagrees with the expectation in the code.
  function automatic logic code_mismatch(input pcode_t c, input logic lvl,
                                         input logic floating);
    logic bad;
    case (c)
      PC_EXPL: bad = floating | lvl;
      PC_EXPH: bad = floating | ~lvl;
      PC_EXPZ: bad = ~floating;
      default: bad = 1'b0;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/tva_vecmem.sv
module tva_vecmem #(
  parameter int AW    = 4,
  parameter int ROW_W = 23
) (
  input  logic             clk,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [ROW_W-1:0] ld_row,
  input  logic [AW-1:0]    rd_addr,
  output logic [ROW_W-1:0] rd_row
);
  localparam int DEPTH = 1 << AW;

  logic [ROW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_row;
  end

  assign rd_row = mem[rd_addr];
endmodule

// File: rtl/tva_pin_cell.sv
module tva_pin_cell
  import tva_pkg::*;
(
  input  logic   active,
  input  pcode_t code,
  input  logic   pin_lvl,
  input  logic   pin_float,
  output logic   drv_en,
  output logic   drv_val,
  output logic   mism
);
  assign drv_en  = active & code_drives(code);
  assign drv_val = drv_en & code[0];
  assign mism    = active & code_mismatch(code, pin_lvl, pin_float);
endmodule

// File: rtl/tva_seq.sv
module tva_seq
  import tva_pkg::*;
#(
  parameter int AW  = 4,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [OPW-1:0] operand,
  output logic [AW-1:0]  pc,
  output logic           busy,
  output logic           done,
  output logic           evt_start,
  output logic           evt_advance,
  output logic           evt_rpt_hold,
  output logic           evt_loop_back,
  output logic           evt_jump,
  output logic           evt_halt,
  output logic [AW-1:0]  jmp_tgt,
  output logic [AW-1:0]  loop_tgt
);
  logic [AW-1:0]  pc_q, pc_d, lstart_q, lstart_d;
  logic [OPW-1:0] rpt_q, rpt_d, loop_q, loop_d;
  logic           busy_q, done_q;

  // Last cycle of a repeat: count of cycles already spent reaches K (0 acts as 1).
  function automatic logic rpt_last(input logic [OPW-1:0] cnt,
                                    input logic [OPW-1:0] k);
    logic [OPW:0] spent, lim;
    spent = {1'b0, cnt} + (OPW+1)'(1);
    lim   = (k == '0) ? (OPW+1)'(1) : {1'b0, k};
    return spent >= lim;
  endfunction

  // Extra passes of a loop block after the first one (M=0 acts as 1).
  function automatic logic [OPW-1:0] loop_reload(input logic [OPW-1:0] m);
    return (m == '0) ? '0 : m - OPW'(1);
  endfunction

  assign evt_start = start & ~busy_q;
  assign jmp_tgt   = operand[AW-1:0];
  assign loop_tgt  = lstart_q;

  always_comb begin
    pc_d          = pc_q;
    rpt_d         = rpt_q;
    loop_d        = loop_q;
    lstart_d      = lstart_q;
    evt_advance   = 1'b0;
    evt_rpt_hold  = 1'b0;
    evt_loop_back = 1'b0;
    evt_jump      = 1'b0;
    evt_halt      = 1'b0;
    if (busy_q) begin
      case (op_e'(op))
        OP_RPT: begin
          if (rpt_last(rpt_q, operand)) begin
            rpt_d       = '0;
            evt_advance = 1'b1;
          end else begin
            rpt_d        = rpt_q + OPW'(1);
            evt_rpt_hold = 1'b1;
          end
        end
        OP_LBEG: begin
          loop_d      = loop_reload(operand);
          lstart_d    = pc_q + AW'(1);
          evt_advance = 1'b1;
        end
        OP_LEND: begin
          if (loop_q != '0) begin
            loop_d        = loop_q - OPW'(1);
            evt_loop_back = 1'b1;
          end else begin
            evt_advance = 1'b1;
          end
        end
        OP_JMP:  evt_jump = 1'b1;
        OP_HALT: evt_halt = 1'b1;
        default: evt_advance = 1'b1;
      endcase
      if (evt_advance)   pc_d = pc_q + AW'(1);
      if (evt_loop_back) pc_d = lstart_q;
      if (evt_jump)      pc_d = jmp_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pc_q     <= '0;
      rpt_q    <= '0;
      loop_q   <= '0;
      lstart_q <= '0;
    end else if (evt_start) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      pc_q     <= '0;
      rpt_q    <= '0;
      loop_q   <= '0;
      lstart_q <= '0;
    end else if (busy_q) begin
      if (evt_halt) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      pc_q     <= pc_d;
      rpt_q    <= rpt_d;
      loop_q   <= loop_d;
      lstart_q <= lstart_d;
    end
  end

  assign pc   = pc_q;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/tva_fail_log.sv
module tva_fail_log #(
  parameter int NPINS = 4,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [NPINS-1:0] mism,
  input  logic [AW-1:0]    addr,
  output logic [NPINS-1:0] fail_pins,
  output logic             any_fail,
  output logic [AW-1:0]    first_addr
);
  logic [NPINS-1:0] flags_q;
  logic             any_q;
  logic [AW-1:0]    first_q;
  logic             hit;

  assign hit = |mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      any_q   <= 1'b0;
      first_q <= '0;
    end else if (clear) begin
      flags_q <= '0;
      any_q   <= 1'b0;
      first_q <= '0;
    end else begin
      flags_q <= flags_q | mism;
      if (hit && !any_q) begin
        any_q   <= 1'b1;
        first_q <= addr;
      end
    end
  end

  assign fail_pins  = flags_q;
  assign any_fail   = any_q;
  assign first_addr = first_q;
endmodule

// File: rtl/tva_engine.sv
module tva_engine
  import tva_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int AW    = 4,
  parameter int OPW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [AW-1:0]             ld_addr,
  input  logic [NPINS*3+3+OPW-1:0]  ld_row,
  input  logic                      start,
  input  logic [NPINS-1:0]          pin_in,
  input  logic [NPINS-1:0]          pin_z,
  output logic [NPINS-1:0]          drive_en,
  output logic [NPINS-1:0]          drive_val,
  output logic                      busy,
  output logic                      done,
  output logic [AW-1:0]             cur_addr,
  output logic [NPINS-1:0]          fail_pins,
  output logic                      any_fail,
  output logic [AW-1:0]             first_addr
);
  localparam int OP_LSB  = NPINS * 3;
  localparam int OPR_LSB = OP_LSB + 3;
  localparam int ROW_W   = OPR_LSB + OPW;

  logic [ROW_W-1:0] row;
  logic [AW-1:0]    pc;
  logic [NPINS-1:0] mism;
  logic             evt_start, evt_advance, evt_rpt_hold;
  logic             evt_loop_back, evt_jump, evt_halt;
  logic [AW-1:0]    jmp_tgt, loop_tgt;

  tva_vecmem #(.AW(AW), .ROW_W(ROW_W)) u_mem (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_row  (ld_row),
    .rd_addr (pc),
    .rd_row  (row)
  );

  tva_seq #(.AW(AW), .OPW(OPW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .op            (row[OP_LSB +: 3]),
    .operand       (row[OPR_LSB +: OPW]),
    .pc            (pc),
    .busy          (busy),
    .done          (done),
    .evt_start     (evt_start),
    .evt_advance   (evt_advance),
    .evt_rpt_hold  (evt_rpt_hold),
    .evt_loop_back (evt_loop_back),
    .evt_jump      (evt_jump),
    .evt_halt      (evt_halt),
    .jmp_tgt       (jmp_tgt),
    .loop_tgt      (loop_tgt)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    tva_pin_cell u_cell (
      .active    (busy),
      .code      (row[3*p +: 3]),
      .pin_lvl   (pin_in[p]),
      .pin_float (pin_z[p]),
      .drv_en    (drive_en[p]),
      .drv_val   (drive_val[p]),
      .mism      (mism[p])
    );
  end

  tva_fail_log #(.NPINS(NPINS), .AW(AW)) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (evt_start),
    .mism       (mism),
    .addr       (pc),
    .fail_pins  (fail_pins),
    .any_fail   (any_fail),
    .first_addr (first_addr)
  );

  assign cur_addr = pc;
endmodule

// File: rtl/tva_engine_chk.sv
module tva_engine_chk #(
  parameter int NPINS = 4,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [NPINS-1:0] drive_en,
  input logic [AW-1:0]    cur_addr,
  input logic [NPINS-1:0] fail_pins,
  input logic             any_fail,
  input logic [AW-1:0]    first_addr,
  input logic             evt_start,
  input logic             evt_advance,
  input logic             evt_rpt_hold,
  input logic             evt_loop_back,
  input logic             evt_jump,
  input logic             evt_halt,
  input logic [AW-1:0]    jmp_tgt,
  input logic [AW-1:0]    loop_tgt
);
  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> drive_en == '0);

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> (busy && cur_addr == '0 && fail_pins == '0 && !any_fail));

  a_r4_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
    evt_advance |=> cur_addr == $past(cur_addr) + AW'(1));

  a_r5_repeat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rpt_hold |=> (busy && $stable(cur_addr)));

  a_r6_loop_return: assert property (@(posedge clk) disable iff (!rst_n)
    evt_loop_back |=> cur_addr == $past(loop_tgt));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    evt_jump |=> cur_addr == $past(jmp_tgt));

  a_r8_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
    evt_halt |=> (!busy && done));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_start |=> (fail_pins & $past(fail_pins)) == $past(fail_pins));

  a_r10_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fail && !evt_start) |=> (any_fail && $stable(first_addr)));
endmodule

bind tva_engine tva_engine_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .drive_en      (drive_en),
  .cur_addr      (cur_addr),
  .fail_pins     (fail_pins),
  .any_fail      (any_fail),
  .first_addr    (first_addr),
  .evt_start     (evt_start),
  .evt_advance   (evt_advance),
  .evt_rpt_hold  (evt_rpt_hold),
  .evt_loop_back (evt_loop_back),
  .evt_jump      (evt_jump),
  .evt_halt      (evt_halt),
  .jmp_tgt       (jmp_tgt),
  .loop_tgt      (loop_tgt)
);

// File: tb/sim_tva_engine.sv
module sim_tva_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 4;
  localparam int AW    = 4;
  localparam int OPW   = 8;
  localparam int ROW_W = NPINS * 3 + 3 + OPW;
  localparam int DEPTH = 16;
  localparam int MAXS  = 64;

  localparam logic [2:0] C0 = 3'b000, C1 = 3'b001, CL = 3'b010, CH = 3'b011;
  localparam logic [2:0] CZ = 3'b100, CU = 3'b101, CV = 3'b110, CX = 3'b111;
  localparam logic [2:0] O_ADV = 3'd0, O_RPT = 3'd1, O_LB = 3'd2, O_LE = 3'd3;
  localparam logic [2:0] O_JMP = 3'd4, O_HALT = 3'd5, O_SP = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [ROW_W-1:0] ld_row = '0;
  logic start = 1'b0;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_z = '0;
  logic [NPINS-1:0] drive_en, drive_val, fail_pins;
  logic busy, done, any_fail;
  logic [AW-1:0] cur_addr, first_addr;

  tva_engine #(.NPINS(NPINS), .AW(AW), .OPW(OPW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_row(ld_row), .start(start), .pin_in(pin_in), .pin_z(pin_z),
    .drive_en(drive_en), .drive_val(drive_val), .busy(busy), .done(done),
    .cur_addr(cur_addr), .fail_pins(fail_pins), .any_fail(any_fail),
    .first_addr(first_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [ROW_W-1:0] prog [DEPTH];
  logic [NPINS-1:0] rv [MAXS];
  logic [NPINS-1:0] rz [MAXS];
  logic [AW+2*NPINS-1:0] sbq [$];
  logic [NPINS-1:0] efp;
  logic eany;
  logic [AW-1:0] efirst;
  int checks = 0;
  int failures = 0;
  int step = 0;
  int cyc = 0;
  string tag = "R11";

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ROW_W-1:0] mk(input logic [2:0] op,
      input logic [OPW-1:0] opr, input logic [2:0] c3, input logic [2:0] c2,
      input logic [2:0] c1, input logic [2:0] c0);
    return {opr, op, c3, c2, c1, c0};
  endfunction

  // Expectation rules restated from R2.
  function automatic bit pin_bad(input logic [2:0] c, input logic v,
                                 input logic z);
    if (c == CL) return z || v;
    if (c == CH) return z || !v;
    if (c == CZ) return !z;
    return 0;
  endfunction

  task automatic clear_prog();
    for (int a = 0; a < DEPTH; a++) prog[a] = mk(O_HALT, 0, CX, CX, CX, CX);
    for (int s = 0; s < MAXS; s++) begin rv[s] = '0; rz[s] = '0; end
  endtask

  // Driver side: walk the program from the requirements and queue expected cycles.
  task automatic build_expect();
    int pc = 0, rc = 0, lc = 0, ls = 0, s = 0, k;
    bit fin = 0;
    logic [ROW_W-1:0] r;
    logic [2:0] op, c;
    logic [OPW-1:0] opr;
    logic [NPINS-1:0] den, dv;
    sbq.delete();
    efp = '0; eany = 0; efirst = '0;
    while (!fin && s < MAXS) begin
      r = prog[pc];
      op = r[3*NPINS +: 3];
      opr = r[3*NPINS+3 +: OPW];
      den = '0; dv = '0;
      for (int i = 0; i < NPINS; i++) begin
        c = r[3*i +: 3];
        if (c == C0 || c == C1) begin den[i] = 1; dv[i] = c[0]; end
        if (pin_bad(c, rv[s][i], rz[s][i])) begin
          efp[i] = 1;
          if (!eany) begin eany = 1; efirst = pc[AW-1:0]; end
        end
      end
      sbq.push_back({pc[AW-1:0], den, dv});
      s++;
      case (op)
        O_RPT: begin
          k = (opr == 0) ? 1 : int'(opr);
          if (rc + 1 >= k) begin rc = 0; pc = (pc + 1) % DEPTH; end
          else rc++;
        end
        O_LB: begin
          lc = (opr == 0) ? 0 : int'(opr) - 1;
          ls = (pc + 1) % DEPTH;
          pc = (pc + 1) % DEPTH;
        end
        O_LE: if (lc != 0) begin lc--; pc = ls; end else pc = (pc + 1) % DEPTH;
        O_JMP: pc = int'(opr) % DEPTH;
        O_HALT: fin = 1;
        default: pc = (pc + 1) % DEPTH;
      endcase
    end
  endtask

  // Monitor: act as the device each busy cycle and pop/compare expected items.
  always @(negedge clk) begin
    if (rst_n && busy) begin
      pin_in <= (step < MAXS) ? rv[step] : '0;
      pin_z  <= (step < MAXS) ? rz[step] : '0;
      if (sbq.size() == 0) chk({tag, " extra cycle"}, {20'd0, cur_addr, drive_en, drive_val}, 32'hFFFF);
      else chk({tag, " cycle"}, {20'd0, cur_addr, drive_en, drive_val}, {20'd0, sbq.pop_front()});
      step++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input string t, input int intr_at);
    int n = 0;
    tag = t;
    build_expect();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_en = 1; ld_addr = a[AW-1:0]; ld_row = prog[a];
    end
    @(negedge clk);
    ld_en = 0;
    step = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    // R3: run begins with cleared records
    chk("R3 busy after start", {31'd0, busy}, 1);
    chk("R3 fail cleared", {27'd0, any_fail, fail_pins}, 0);
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      start = (n == intr_at);
    end
    start = 0;
    chk({t, " R8 done"}, {30'd0, busy, done}, 2'b01);
    chk({t, " queue drained"}, sbq.size(), 0);
    chk({t, " R1 drivers off"}, {28'd0, drive_en}, 0);
    chk({t, " R9 pin flags"}, {28'd0, fail_pins}, {28'd0, efp});
    chk({t, " R10 global"}, {31'd0, any_fail}, {31'd0, eany});
    if (eany) chk({t, " R10 first addr"}, {28'd0, first_addr}, {28'd0, efirst});
    repeat (3) @(negedge clk);
    chk({t, " R8 done held"}, {30'd0, busy, done}, 2'b01);
  endtask

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    chk("R11 idle", {30'd0, busy, done}, 0);
    chk("R11 fails", {23'd0, any_fail, first_addr, fail_pins}, 0);
    chk("R11 R1 no drive", {28'd0, drive_en}, 0);
    rst_n = 1;
    @(negedge clk);

    // P1: drive codes, pass compares, unused codes, spare opcode (R1, R2, R4)
    clear_prog();
    prog[0] = mk(O_ADV, 0, C0, C1, CH, CL);  rv[0] = 4'b0010;
    prog[1] = mk(O_ADV, 0, CX, CZ, CL, CH);  rv[1] = 4'b0001; rz[1] = 4'b0100;
    prog[2] = mk(O_SP, 0, CU, CV, CU, CV);   rv[2] = 4'b1111; rz[2] = 4'b1010;
    prog[3] = mk(O_HALT, 0, C1, CX, CX, CX);
    run("R4", 0);
    chk("R2 no fail on pass pattern", {31'd0, any_fail}, 0);

    // P2: repeat counts, failure only in the third held cycle (R5)
    clear_prog();
    prog[0] = mk(O_RPT, 3, CX, CX, C1, CH);
    rv[0] = 4'b0001; rv[1] = 4'b0001; rv[2] = 4'b0000;
    prog[1] = mk(O_RPT, 0, C1, CX, CX, CX);
    prog[2] = mk(O_RPT, 1, CX, C0, CX, CX);
    prog[3] = mk(O_HALT, 0, CX, CX, CX, CX);
    run("R5", 0);
    chk("R5 late repeat fail seen", {28'd0, fail_pins}, 4'b0001);

    // P3: loops with count 3 and 0, plus a stray start mid-run (R6, R3)
    clear_prog();
    prog[0] = mk(O_LB, 3, C1, CX, CX, CX);
    prog[1] = mk(O_ADV, 0, CX, C1, CX, CX);
    prog[2] = mk(O_LE, 0, CX, CX, C0, CX);
    prog[3] = mk(O_LB, 0, CX, CX, CX, C1);
    prog[4] = mk(O_LE, 0, C0, CX, CX, CX);
    prog[5] = mk(O_HALT, 0, CX, CX, CX, CX);
    run("R6", 4);

    // P4: jumps, one with high operand bits (R7)
    clear_prog();
    prog[0] = mk(O_JMP, 5, CX, CX, CX, C1);
    for (int a = 1; a < 5; a++) prog[a] = mk(O_ADV, 0, CH, CH, CH, CH);
    prog[5] = mk(O_ADV, 0, C1, CX, CX, CX);
    prog[6] = mk(O_JMP, 8'h1A, CX, C0, CX, CX);
    prog[10] = mk(O_HALT, 0, CX, CX, CX, CX);
    run("R7", 0);
    chk("R7 skipped rows not compared", {31'd0, any_fail}, 0);

    // P5: each expect kind fails on a different row, flags stick (R2, R9, R10)
    clear_prog();
    prog[0] = mk(O_ADV, 0, CX, CX, CX, CX);  rv[0] = 4'b1010; rz[0] = 4'b0101;
    prog[1] = mk(O_ADV, 0, CX, CH, CX, CX);  rv[1] = 4'b0000;
    prog[2] = mk(O_ADV, 0, CX, CX, CX, CZ);  rz[2] = 4'b0000;
    prog[3] = mk(O_ADV, 0, CX, CX, CL, CX);  rz[3] = 4'b0010;
    prog[4] = mk(O_ADV, 0, CL, CH, CX, CX);  rv[4] = 4'b0100;
    prog[5] = mk(O_HALT, 0, CX, CX, CX, CX);
    run("R9", 0);
    chk("R2 all three expect kinds", {28'd0, fail_pins}, 4'b0111);
    chk("R10 first failing row", {28'd0, first_addr}, 1);

    // P6: rerun a passing program, records cleared by start (R3)
    clear_prog();
    prog[0] = mk(O_ADV, 0, C0, C1, CH, CL);  rv[0] = 4'b0010;
    prog[1] = mk(O_HALT, 0, CX, CX, CX, CX);
    run("R3", 0);
    chk("R3 fails gone after rerun", {31'd0, any_fail}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule